// File: doc/BRIEF.md
# Indirect Address Byte Port Bridge

This bridge lets a host that sees only four byte-wide I/O slots reach a much larger byte-addressed memory. A 16-bit pointer register inside the bridge selects the memory byte. The host loads the pointer one byte at a time through two slots, then moves data through a third slot. The fourth slot in the window does nothing. The bridge drives a downstream byte port with an address, write data, a write strobe and a read strobe, and takes back read data one cycle after the read strobe.

Host requests use a valid/ready handshake. A request takes effect only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops for exactly one cycle after an accepted read, while that read's response is on the bus. The host must hold its request stable until it is accepted. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the host must capture when it appears.

The window position is a parameter. The slot number is the incoming address minus that base, taken modulo the address width. A write of data through the data slot clears the pointer to zero afterwards. A read through the data slot leaves the pointer unchanged.

Top module: `ioptr_bridge`

## Requirements
- R1: After reset the pointer is 0x0000, which shows on `mem_addr`. `rsp_valid`, `mem_we` and `mem_re` are low and `req_ready` is high.
- R2: An accepted write to slot 0 loads the pointer's low byte with the data and keeps its high byte. The new pointer shows on `mem_addr` from the next cycle.
- R3: An accepted write to slot 1 loads the pointer's high byte with the data and keeps its low byte.
- R4: An accepted write to slot 3 pulses `mem_we` in the accept cycle, with `mem_addr` equal to the current pointer and `mem_wdata` equal to the data. From the next cycle the pointer is 0x0000.
- R5: An accepted read of slot 3 pulses `mem_re` in the accept cycle at the current pointer. In the next cycle `rsp_valid` is high and `rsp_data` carries `mem_rdata`. The pointer is unchanged.
- R6: An accepted read of slot 0, 1 or 2 produces no strobe. In the next cycle `rsp_valid` is high and `rsp_data` is 0xFF.
- R7: An accepted write to slot 2 produces no strobe, no response and no pointer change.
- R8: A request is outside the window when (`req_addr` − BASE) mod 2^16 is 4 or more. Such a request produces no strobe, no response and no pointer change.
- R9: In the cycle after an accepted read, `req_ready` is low. A request held during that cycle has no effect until it is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host I/O address |
| req_wdata | input | 8 | Host write byte |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 8 | Read response byte |
| mem_addr | output | 16 | Downstream byte address (the pointer) |
| mem_wdata | output | 8 | Downstream write byte |
| mem_we | output | 1 | Downstream write strobe |
| mem_re | output | 1 | Downstream read strobe |
| mem_rdata | input | 8 | Downstream read byte, valid one cycle after `mem_re` |

## Verification
Several properties are checked on every cycle:
- how each pointer load keeps the other byte;
- that the pointer is cleared after a data write;
- that a response follows every decoded read;
- that out-of-window requests and stalled cycles stay silent;
- that the address holds steady across a downstream read.

Only the bench's scenarios can show the values that actually come back. These include the 0xFF fill for the unused slots and the data read back after a write. They also include reading address zero right after the automatic clear and the sequence of a request held across a stall.

// File: rtl/ioptr_pkg.sv
package ioptr_pkg;

  // Number of byte slots in the host window and bits needed to index them.
  localparam int unsigned WIN_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(WIN_SLOTS);

  // Slot assignment inside the window.
  localparam logic [SLOT_W-1:0] SLOT_PTR_LO = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_PTR_HI = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_GAP    = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_DATA   = 2'd3;

  // Decoded action for one accepted request.
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_PTR_LO,
    CMD_PTR_HI,
    CMD_DATA_WR,
    CMD_DATA_RD,
    CMD_FILL_RD
  } cmd_e;

endpackage

// File: rtl/ioptr_decode.sv
module ioptr_decode
  import ioptr_pkg::*;
#(
  parameter int unsigned          IO_AW = 16,
  parameter logic [IO_AW-1:0]     BASE  = 16'h0070
) (
  input  logic             fire,
  input  logic             write,
  input  logic [IO_AW-1:0] addr,
  output cmd_e             cmd,
  output logic             in_window
);

  logic [IO_AW-1:0]  rel;
  logic [SLOT_W-1:0] slot;

  // Relative address wraps modulo 2^IO_AW.
  assign rel       = addr - BASE;
  assign slot      = rel[SLOT_W-1:0];
  assign in_window = (rel[IO_AW-1:SLOT_W] == '0);

  always_comb begin
    cmd = CMD_NONE;
    if (fire && in_window) begin
      if (write) begin
        unique case (slot)
          SLOT_PTR_LO: cmd = CMD_PTR_LO;
          SLOT_PTR_HI: cmd = CMD_PTR_HI;
          SLOT_DATA:   cmd = CMD_DATA_WR;
          default:     cmd = CMD_NONE;     // gap slot: write dropped
        endcase
      end else begin
        if (slot == SLOT_DATA) cmd = CMD_DATA_RD;
        else                   cmd = CMD_FILL_RD;
      end
    end
  end

endmodule

// File: rtl/ioptr_pointer.sv
module ioptr_pointer
  import ioptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANES = 2,
  localparam int unsigned PTR_W = LANES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);

  // One register per byte lane; a lane loads on its own command and
  // every lane clears after a data write.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam cmd_e LOAD_CMD = (k == 0) ? CMD_PTR_LO : CMD_PTR_HI;
    logic [DATA_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lane_q <= '0;
      else if (cmd == CMD_DATA_WR)  lane_q <= '0;
      else if (cmd == LOAD_CMD)     lane_q <= wdata;
    end

    assign ptr[k*DATA_W +: DATA_W] = lane_q;
  end

  // R2: low-byte load keeps the high byte
  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_PTR_LO |=> (ptr[DATA_W-1:0] == $past(wdata)) &&
                          (ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W])));

  // R3: high-byte load keeps the low byte
  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_PTR_HI |=> (ptr[PTR_W-1:DATA_W] == $past(wdata)) &&
                          (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])));

  // R4: pointer is zero after a data write
  p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_DATA_WR |=> ptr == '0);

  // R5 / R6 / R7: reads and the gap slot leave the pointer alone
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA_RD || cmd == CMD_FILL_RD || cmd == CMD_NONE) |=> $stable(ptr));

endmodule

// File: rtl/ioptr_resp.sv
module ioptr_resp
  import ioptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy
);

  logic vld_q;
  logic from_mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      from_mem_q <= 1'b0;
    end else begin
      vld_q      <= (cmd == CMD_DATA_RD) || (cmd == CMD_FILL_RD);
      from_mem_q <= (cmd == CMD_DATA_RD);
    end
  end

  assign rsp_valid = vld_q;
  assign busy      = vld_q;
  assign rsp_data  = from_mem_q ? mem_rdata : '1;

  // R5 / R6: every decoded read is answered in the next cycle
  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA_RD || cmd == CMD_FILL_RD) |=> rsp_valid);

  // R7: writes and undecoded requests produce no response
  p_no_rsp_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PTR_LO || cmd == CMD_PTR_HI || cmd == CMD_DATA_WR || cmd == CMD_NONE)
      |=> !rsp_valid);

endmodule

// File: rtl/ioptr_bridge.sv
module ioptr_bridge
  import ioptr_pkg::*;
#(
  parameter int unsigned      IO_AW  = 16,
  parameter int unsigned      DATA_W = 8,
  parameter logic [IO_AW-1:0] BASE   = 16'h0070,
  localparam int unsigned     PTR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IO_AW-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  cmd_e             cmd;
  logic             fire;
  logic             busy;
  logic             in_window;
  logic [PTR_W-1:0] ptr;

  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;

  ioptr_decode #(.IO_AW(IO_AW), .BASE(BASE)) u_decode (
    .fire      (fire),
    .write     (req_write),
    .addr      (req_addr),
    .cmd       (cmd),
    .in_window (in_window)
  );

  ioptr_pointer #(.DATA_W(DATA_W)) u_pointer (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .wdata (req_wdata),
    .ptr   (ptr)
  );

  ioptr_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .busy      (busy)
  );

  assign mem_addr  = ptr;
  assign mem_wdata = req_wdata;
  assign mem_we    = (cmd == CMD_DATA_WR);
  assign mem_re    = (cmd == CMD_DATA_RD);

  // R8: requests outside the window touch nothing
  p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_window) |-> !mem_we && !mem_re);
  p_outside_norsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_window) |=> !rsp_valid && $stable(mem_addr));

  // R9: no downstream strobe while the host side is stalled
  p_stall_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_we && !mem_re);

  // R9: an accepted read stalls the next cycle
  p_read_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && in_window) |=> !req_ready);

  // R5: address held across the downstream read latency
  p_rd_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> $stable(mem_addr));

endmodule

// File: tb/ioptr_bridge_test.sv
module ioptr_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ioptr_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // Downstream memory model: one cycle of read latency, indexed by the low byte.
  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One handshake; returns the strobes seen in the accept cycle and the
  // response / pointer seen one cycle later.
  task automatic do_req(input logic w, input logic [15:0] a, input logic [7:0] d,
                        output logic we_s, output logic re_s,
                        output logic [15:0] addr_s, output logic [7:0] wd_s,
                        output logic rv, output logic [7:0] rd, output logic [15:0] ptr_after);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    we_s = mem_we; re_s = mem_re; addr_s = mem_addr; wd_s = mem_wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    rv = rsp_valid; rd = rsp_data; ptr_after = mem_addr;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] exp_ptr;
    logic        exp_rv;
    logic [7:0]  exp_rd;
    logic [7:0]  tag;
  } vec_t;

  // BASE = 0x0070; memory preset to index ^ 0x5A
  localparam vec_t TBL [18] = '{
    '{1'b1, 16'h0070, 8'h34, 16'h0034, 1'b0, 8'h00, 8'd2},  // R2
    '{1'b1, 16'h0071, 8'h12, 16'h1234, 1'b0, 8'h00, 8'd3},  // R3
    '{1'b0, 16'h0073, 8'h00, 16'h1234, 1'b1, 8'h6E, 8'd5},  // R5
    '{1'b1, 16'h0072, 8'h99, 16'h1234, 1'b0, 8'h00, 8'd7},  // R7
    '{1'b0, 16'h0070, 8'h00, 16'h1234, 1'b1, 8'hFF, 8'd6},  // R6
    '{1'b0, 16'h0071, 8'h00, 16'h1234, 1'b1, 8'hFF, 8'd6},  // R6
    '{1'b0, 16'h0072, 8'h00, 16'h1234, 1'b1, 8'hFF, 8'd6},  // R6
    '{1'b1, 16'h0074, 8'h55, 16'h1234, 1'b0, 8'h00, 8'd8},  // R8
    '{1'b1, 16'h006F, 8'h00, 16'h1234, 1'b0, 8'h00, 8'd8},  // R8
    '{1'b0, 16'h0075, 8'h00, 16'h1234, 1'b0, 8'h00, 8'd8},  // R8
    '{1'b1, 16'h0073, 8'hC3, 16'h0000, 1'b0, 8'h00, 8'd4},  // R4
    '{1'b1, 16'h0070, 8'h34, 16'h0034, 1'b0, 8'h00, 8'd2},  // R2
    '{1'b0, 16'h0073, 8'h00, 16'h0034, 1'b1, 8'hC3, 8'd5},  // R5
    '{1'b1, 16'h0071, 8'hAB, 16'hAB34, 1'b0, 8'h00, 8'd3},  // R3
    '{1'b1, 16'h0070, 8'h01, 16'hAB01, 1'b0, 8'h00, 8'd2},  // R2
    '{1'b0, 16'h0073, 8'h00, 16'hAB01, 1'b1, 8'h5B, 8'd5},  // R5
    '{1'b1, 16'h0073, 8'h77, 16'h0000, 1'b0, 8'h00, 8'd4},  // R4
    '{1'b0, 16'h0073, 8'h00, 16'h0000, 1'b1, 8'h5A, 8'd5}   // R5
  };

  initial begin
    logic we_s, re_s, rv;
    logic [15:0] addr_s, ptr_after, ptr_before;
    logic [7:0] wd_s, rd;
    string tg;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_addr == 16'h0000, "R1", "pointer", 32'(mem_addr), 32'h0);
    check(!rsp_valid && !mem_we && !mem_re, "R1", "outputs idle",
          {29'd0, rsp_valid, mem_we, mem_re}, 32'h0);
    check(req_ready, "R1", "ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;

    ptr_before = 16'h0000;
    foreach (TBL[i]) begin
      logic exp_we, exp_re;
      tg = $sformatf("R%0d", TBL[i].tag);
      exp_we = TBL[i].wr && TBL[i].addr == 16'h0073;
      exp_re = !TBL[i].wr && TBL[i].addr == 16'h0073;
      do_req(TBL[i].wr, TBL[i].addr, TBL[i].data, we_s, re_s, addr_s, wd_s, rv, rd, ptr_after);
      check(we_s == exp_we && re_s == exp_re && (!(exp_we || exp_re) || addr_s == ptr_before)
            && (!exp_we || wd_s == TBL[i].data), tg, "strobes",
            {we_s, re_s, addr_s, wd_s}, {exp_we, exp_re, ptr_before, TBL[i].data});
      check(rv == TBL[i].exp_rv && (!rv || rd == TBL[i].exp_rd), tg, "response",
            {rv, rd}, {TBL[i].exp_rv, TBL[i].exp_rd});
      check(ptr_after == TBL[i].exp_ptr, tg, "pointer", 32'(ptr_after), 32'(TBL[i].exp_ptr));
      ptr_before = TBL[i].exp_ptr;
    end

    // R9: request held across the stall cycle after a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0073;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 16'h0070; req_wdata = 8'hEE;
    #1;
    check(!req_ready, "R9", "ready low after read", 32'(req_ready), 32'h0);
    check(rsp_valid && rsp_data == 8'h5A, "R9", "response during stall",
          {rsp_valid, rsp_data}, {1'b1, 8'h5A});
    check(!mem_we && !mem_re, "R9", "no strobe in stall", {mem_we, mem_re}, 32'h0);
    @(negedge clk);
    #1;
    check(mem_addr == 16'h0000 && req_ready, "R9", "stalled write not applied",
          {req_ready, mem_addr}, {1'b1, 16'h0000});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(mem_addr == 16'h00EE, "R9", "held write applied", 32'(mem_addr), 32'h00EE);

    // R1: reset again clears a loaded pointer
    rst_n = 1'b0;
    #1;
    check(mem_addr == 16'h0000, "R1", "pointer after second reset", 32'(mem_addr), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule